// File: doc/BRIEF.md
# Fixed-Length Block Read Checker

This block watches characters as they are read from tape into a block-sized memory and confirms that every block holds exactly the expected number of characters (120 by default). Each character arrives as two single-cycle sprocket strobes: an early phase and a late phase. The block keeps the memory write address, says whether that address exists, and gates the write pulse for each character. A retriggerable gap timer, restarted by every strobe, finds the silence between blocks and ends the read.

Both length faults go through one error path. Too many characters raise the error on the first surplus character. Too few characters leave the block not full when the gap timer runs out, so the read carries on into the next block on tape. That block's first character fills the last location, and its second character raises the same error. Once the error is set, writes are blocked but the address keeps counting. The error reaches the prevent-print and lamp outputs only while the check-enable switch input is closed.

Top module: `blk_read_checker`

## Requirements
- R1: A one-cycle `read_start` pulse clears the address to 0 and clears the full, error and done state. From then on the block accepts strobes. A strobe in the same cycle as `read_start` is ignored.
- R2: Each accepted late-phase strobe (`spr_b`) raises the address by exactly one after the character's write. Early-phase strobes never move the address. The address saturates at its all-ones value.
- R3: `wr_addr_ok` is 1 exactly when `wr_addr` is below BLOCK_LEN (0 to 119 with the defaults). `wr_en` pulses only in an accepted `spr_b` cycle while the address is valid and the error is clear.
- R4: A late-phase strobe taken at address BLOCK_LEN-1 marks the block full. `read_done` rises only while the block is full.
- R5: An accepted early-phase strobe (`spr_a`) that arrives while the block is full sets `len_err`. `len_err` then holds until the next `read_start`.
- R6: While `len_err` is set, no write pulse is produced. The address still steps once for each later character.
- R7: When GAP_CYCLES clock edges pass with no strobe and the block is full, `read_done` goes to 1. The edge that samples the last strobe is not counted. One clock edge earlier, `read_done` is still 0.
- R8: If the gap timer expires before the block is full, the read does not end. The next block's first character writes address BLOCK_LEN-1. Its second character sets `len_err`. A block one character short followed by exactly one character ends cleanly, with no error.
- R9: `prevent_print` and `chk_lamp` are 1 exactly when `len_err` is 1 and `chk_en` is 1.
- R10: Strobes are ignored before the first `read_start` and after `read_done` rises. The address does not change and no write is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| read_start | input | 1 | One-cycle pulse that begins a read |
| spr_a | input | 1 | Early-phase sprocket strobe of a character |
| spr_b | input | 1 | Late-phase sprocket strobe of a character |
| chk_en | input | 1 | Check-enable switch; 1 lets the error reach the outputs |
| wr_addr | output | $clog2(BLOCK_LEN)+1 | Memory write address (character count) |
| wr_addr_ok | output | 1 | Address selects an existing location |
| wr_en | output | 1 | Write pulse for the current character |
| read_done | output | 1 | Read ended normally on a full block |
| len_err | output | 1 | Sticky length error |
| prevent_print | output | 1 | Length error gated by `chk_en` |
| chk_lamp | output | 1 | Indicator copy of the gated error |

## Verification
A wrong address count shows up at `wr_addr` on the next clock edge. It then either moves the cycle in which `wr_en` stops, or moves the character on which `len_err` rises. A lost or early full flag shows up only when the gap timer runs out: `read_done` stays low, or it rises without an error. So the gap-timeout edge is checked to the exact cycle. Under-length blocks are the delicate case. Their fault appears one block later, on the second character of the next block, so the bench feeds two blocks with a real gap between them and checks the state in the middle of the gap.

// File: rtl/blk_chk_pkg.sv
package blk_chk_pkg;

  // address is a real memory location when below the block length
  function automatic logic addr_in_range(input int unsigned cnt, input int unsigned len);
    return cnt < len;
  endfunction

  // next count value with saturation at the top code
  function automatic int unsigned count_step(input int unsigned cnt, input int unsigned top);
    return (cnt >= top) ? top : cnt + 1;
  endfunction

  // late phase at the last location marks the block full
  function automatic logic is_last_slot(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

endpackage

// File: rtl/blk_addr_ctr.sv
module blk_addr_ctr
  import blk_chk_pkg::*;
#(
  parameter int BLOCK_LEN = 120,
  parameter int CW        = $clog2(BLOCK_LEN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          inhibit,
  output logic [CW-1:0] addr,
  output logic          addr_ok,
  output logic          full_hit,
  output logic          wr_en
);
  localparam int unsigned TOP = (1 << CW) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (clear)  addr <= '0;
    else if (step)   addr <= CW'(count_step(32'(addr), TOP));
  end

  assign addr_ok  = addr_in_range(32'(addr), BLOCK_LEN);
  assign full_hit = step && is_last_slot(32'(addr), BLOCK_LEN);
  assign wr_en    = step && addr_ok && !inhibit;

  // R2: one step per accepted late phase
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && addr != '1) |=> addr == $past(addr) + CW'(1));
  // R2: no movement without a step
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(addr));
endmodule

// File: rtl/blk_gap_timer.sv
module blk_gap_timer #(
  parameter int GAP_CYCLES = 20000,
  parameter int TW         = $clog2(GAP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic kick,
  output logic expire
);
  logic [TW-1:0] cnt;
  logic          armed;

  assign expire = armed && !kick && !clear && (cnt == TW'(GAP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (kick) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (expire) begin
      armed <= 1'b0;
    end else if (armed) begin
      cnt   <= cnt + TW'(1);
    end
  end

  // R7: a strobe always restarts the window
  p_kick_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !expire);
  // R7: expiry is a single pulse per quiet period
  p_single_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/blk_len_check.sv
module blk_len_check (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic phase_a,
  input  logic full_set,
  input  logic expire,
  output logic full_q,
  output logic err_q,
  output logic done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (clear) begin
      full_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (full_set)             full_q <= 1'b1;
      if (phase_a && full_q)    err_q  <= 1'b1;
      if (expire && full_q)     done_q <= 1'b1;
    end
  end

  // R5: error holds until a new read
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear) |=> err_q);
  // R5: error rises only from an early phase on a full block
  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(phase_a && full_q));
  // R4: normal end needs a full block
  p_done_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> full_q);
endmodule

// File: rtl/blk_read_checker.sv
module blk_read_checker #(
  parameter int BLOCK_LEN  = 120,
  parameter int GAP_CYCLES = 20000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       read_start,
  input  logic                       spr_a,
  input  logic                       spr_b,
  input  logic                       chk_en,
  output logic [$clog2(BLOCK_LEN):0] wr_addr,
  output logic                       wr_addr_ok,
  output logic                       wr_en,
  output logic                       read_done,
  output logic                       len_err,
  output logic                       prevent_print,
  output logic                       chk_lamp
);
  localparam int CW = $clog2(BLOCK_LEN) + 1;

  logic started;
  logic live;
  logic take_a, take_b;
  logic full_hit, full_q, gap_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          started <= 1'b0;
    else if (read_start) started <= 1'b1;
  end

  assign live   = started && !read_start && !read_done;
  assign take_a = spr_a && live;
  assign take_b = spr_b && live;

  blk_addr_ctr #(.BLOCK_LEN(BLOCK_LEN), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(read_start), .step(take_b),
    .inhibit(len_err), .addr(wr_addr), .addr_ok(wr_addr_ok),
    .full_hit(full_hit), .wr_en(wr_en)
  );

  blk_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(read_start),
    .kick(take_a || take_b), .expire(gap_expire)
  );

  blk_len_check u_len (
    .clk(clk), .rst_n(rst_n), .clear(read_start), .phase_a(take_a),
    .full_set(full_hit), .expire(gap_expire),
    .full_q(full_q), .err_q(len_err), .done_q(read_done)
  );

  assign prevent_print = len_err && chk_en;
  assign chk_lamp      = len_err && chk_en;

  // R1: a start leaves a clean state
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    read_start |=> (wr_addr == '0 && !len_err && !read_done));
  // R3 / R6: writes only to real locations with no error pending
  p_write_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr_ok && !len_err));
  // R10: a finished read ignores strobes
  p_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !read_start) |=> $stable(wr_addr));
  // R9: report outputs follow the switch
  always_comb begin
    p_report_gate_r9: assert (!rst_n || !prevent_print || chk_en);
  end
endmodule

// File: tb/blk_read_checker_test.sv
module blk_read_checker_test;
  localparam int LEN = 120;
  localparam int GAP = 16;
  localparam int NS  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic read_start = 1'b0, spr_a = 1'b0, spr_b = 1'b0, chk_en = 1'b1;
  logic [$clog2(LEN):0] wr_addr;
  logic wr_addr_ok, wr_en, read_done, len_err, prevent_print, chk_lamp;

  int tests = 0, fails = 0, writes = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blk_read_checker #(.BLOCK_LEN(LEN), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .read_start(read_start), .spr_a(spr_a),
    .spr_b(spr_b), .chk_en(chk_en), .wr_addr(wr_addr), .wr_addr_ok(wr_addr_ok),
    .wr_en(wr_en), .read_done(read_done), .len_err(len_err),
    .prevent_print(prevent_print), .chk_lamp(chk_lamp)
  );

  // scenario table: first block, second block, switch, expected done, error, address, writes
  localparam int T_N1  [NS] = '{120, 121, 125, 119, 119, 119,   0, 240};
  localparam int T_N2  [NS] = '{  0,   0,   0,   5,   0,   1,   0,   0};
  localparam int T_EN  [NS] = '{  1,   1,   0,   1,   1,   1,   1,   1};
  localparam int T_DN  [NS] = '{  1,   1,   1,   1,   0,   1,   0,   1};
  localparam int T_ER  [NS] = '{  0,   1,   1,   1,   0,   0,   0,   1};
  localparam int T_AD  [NS] = '{120, 121, 125, 124, 119, 120,   0, 240};
  localparam int T_WR  [NS] = '{120, 120, 120, 120, 119, 120,   0, 120};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_read();
    @(negedge clk) read_start = 1'b1;
    @(negedge clk) read_start = 1'b0;
  endtask

  task automatic send_chars(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) spr_a = 1'b1;
      @(negedge clk) spr_a = 1'b0;
      @(negedge clk) spr_b = 1'b1;
      #1 if (wr_en) writes++;
      @(negedge clk) spr_b = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 reset addr", int'(wr_addr), 0);
    chk("R1 reset done", int'(read_done), 0);
    chk("R1 reset err", int'(len_err), 0);
    chk("R3 reset addr ok", int'(wr_addr_ok), 1);

    // R10 strobes before any start are ignored
    writes = 0;
    send_chars(3);
    chk("R10 pre-start addr", int'(wr_addr), 0);
    chk("R10 pre-start writes", writes, 0);

    // table walk
    for (int s = 0; s < NS; s++) begin
      chk_en = T_EN[s][0];
      writes = 0;
      start_read();
      chk("R1 start addr", int'(wr_addr), 0);
      send_chars(T_N1[s]);
      idle(GAP + 4);
      if (T_N2[s] > 0) begin
        // R8 short block does not end the read
        chk("R8 mid-gap done", int'(read_done), 0);
        chk("R8 mid-gap addr", int'(wr_addr), T_N1[s]);
        send_chars(T_N2[s]);
        idle(GAP + 4);
      end
      chk("R4 R7 done", int'(read_done), T_DN[s]);
      chk("R5 R8 err", int'(len_err), T_ER[s]);
      chk("R2 addr", int'(wr_addr), T_AD[s]);
      chk("R6 writes", writes, T_WR[s]);
      chk("R3 addr ok", int'(wr_addr_ok), (T_AD[s] < LEN) ? 1 : 0);
      chk("R9 prevent print", int'(prevent_print), T_ER[s] & T_EN[s]);
      chk("R9 lamp", int'(chk_lamp), T_ER[s] & T_EN[s]);
    end

    // R7 exact gap timing
    chk_en = 1'b1;
    start_read();
    send_chars(LEN);
    idle(GAP - 1);
    chk("R7 done one edge early", int'(read_done), 0);
    idle(2);
    chk("R7 done at timeout", int'(read_done), 1);

    // R10 strobes after done are ignored
    writes = 0;
    send_chars(3);
    chk("R10 post-done addr", int'(wr_addr), LEN);
    chk("R10 post-done writes", writes, 0);

    // R1 start in the same cycle as a strobe: strobe ignored
    @(negedge clk) begin read_start = 1'b1; spr_b = 1'b1; end
    @(negedge clk) begin read_start = 1'b0; spr_b = 1'b0; end
    chk("R1 start beats strobe", int'(wr_addr), 0);
    chk("R1 start clears done", int'(read_done), 0);

    // R2 early phase alone never steps
    @(negedge clk) spr_a = 1'b1;
    @(negedge clk) spr_a = 1'b0;
    idle(1);
    chk("R2 early phase only", int'(wr_addr), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule